// File: doc/BRIEF.md
# Double-Buffered Co-processor Memory Wrapper

This block is the shell placed around a compute kernel. Toward the rest of the node it has one data port and one control port. Toward the kernel it has parallel memory ports. Inside are eight dual-port on-chip RAMs: four input buffers and four output buffers. Input buffer k and output buffer k form work pair k.

The external side of every RAM is reached through one flat address range. Through it a DMA engine can fill any input buffer and drain any output buffer. The kernel side of the RAMs gives the kernel four independent read-only ports on the input buffers and four independent write-only ports on the output buffers. All eight kernel ports can be used in the same cycle.

A host first loads input buffer k. It then writes k to the start register. The kernel is told which pair to work on. When the kernel reports completion, the pair's done flag is raised. While the kernel works on one pair, DMA traffic can load or unload another pair, which gives ping-pong operation.

Top module: `cpBufShell`

## Requirements
- R1: After reset the status register reads 0, `krnStart` is low and `extRdata` is 0.
- R2: External address layout: bit [EXT_AW-1] selects output buffers (1) or input buffers (0). The two bits below it select the buffer (0..3). The low WORD_AW bits select the word. Any word of all eight buffers can be written, and can be read back with the data on `extRdata` one cycle after the request.
- R3: Each kernel read port i returns the word of input buffer i at `krnRdAddr[i]` one cycle after the address is presented. The four read ports work independently in the same cycle.
- R4: Each kernel write port i writes `krnWrData[i]` into output buffer i when `krnWrEn[i]` is high. All four may write in the same cycle, and the result can be read on the external port.
- R5: An external access to one buffer and kernel accesses to other buffers in the same cycle all complete correctly.
- R6: A control write to address 0 with `ctlWdata[1:0]`=k, where pair k is not busy, gives the following result one cycle later: a single-cycle `krnStart` pulse with `krnStartIdx`=k, and status busy bit k set.
- R7: A start write for a pair that is already busy produces no `krnStart` pulse and leaves the busy bits unchanged. It also sets the error status bit.
- R8: A `krnDone` pulse with `krnDoneIdx`=k clears busy bit k and sets done bit k. The done bit stays set across status reads until it is cleared.
- R9: A control write to address 1 clears done bit k where `ctlWdata[4+k]` is 1, and clears the error bit where `ctlWdata[8]` is 1. A done event in the same cycle as a clear of the same bit leaves the bit set.
- R10: A control read of address 1 returns {error[8], done[7:4], busy[3:0]} on `ctlRdata` one cycle later. A read of address 0 returns 0. `ctlRdata` holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extEn | input | 1 | External data port access request |
| extWe | input | 1 | External write (1) or read (0) |
| extAddr | input | EXT_AW | Flat buffer address |
| extWdata | input | DATA_W | External write data |
| extRdata | output | DATA_W | External read data, one cycle latency |
| ctlEn | input | 1 | Control port access request |
| ctlWe | input | 1 | Control write (1) or read (0) |
| ctlAddr | input | 2 | 0 start, 1 status |
| ctlWdata | input | 9 | Control write data |
| ctlRdata | output | 9 | Control read data, one cycle latency |
| krnStart | output | 1 | Start pulse to the kernel |
| krnStartIdx | output | 2 | Pair the kernel is to process |
| krnDone | input | 1 | Kernel completion pulse |
| krnDoneIdx | input | 2 | Pair that completed |
| krnRdAddr | input | 4 x WORD_AW | Kernel read addresses, one per input buffer |
| krnRdData | output | 4 x DATA_W | Kernel read data, one cycle latency |
| krnWrEn | input | 4 | Kernel write enables, one per output buffer |
| krnWrAddr | input | 4 x WORD_AW | Kernel write addresses |
| krnWrData | input | 4 x DATA_W | Kernel write data |

## Verification
The assertions take it for granted that `ctlWdata` and `ctlAddr` are stable throughout a control access. They also assume that read data is consumed before the next request, since the output registers change only on a read of their own port. The bench drives every request for exactly one cycle, at the falling edge. It never writes the same output buffer word from both sides in one cycle, because the checks do not define an order for that case. Kernel done pulses are raised only for pairs the bench has started.

// File: rtl/cpShellPkg.sv
package cpShellPkg;
  localparam int NUM_PAIRS = 4;
  localparam int NUM_BUFS  = 2 * NUM_PAIRS;
  localparam int BUF_SEL_W = $clog2(NUM_BUFS);
  localparam int PAIR_W    = $clog2(NUM_PAIRS);
  localparam int CTL_W     = 2 * NUM_PAIRS + 1;
  localparam logic [1:0] CTL_START  = 2'd0;
  localparam logic [1:0] CTL_STATUS = 2'd1;

  typedef struct packed {
    logic [NUM_BUFS-1:0]  wrSel;
    logic                 rdStrobe;
    logic [BUF_SEL_W-1:0] bufSel;
  } extStrobe_t;
endpackage

// File: rtl/cpShellCtrl.sv
module cpShellCtrl
  import cpShellPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 extEn,
  input  logic                 extWe,
  input  logic [BUF_SEL_W-1:0] extBufSel,
  input  logic                 ctlEn,
  input  logic                 ctlWe,
  input  logic [1:0]           ctlAddr,
  input  logic [CTL_W-1:0]     ctlWdata,
  output logic [CTL_W-1:0]     ctlRdata,
  output logic                 krnStart,
  output logic [PAIR_W-1:0]    krnStartIdx,
  input  logic                 krnDone,
  input  logic [PAIR_W-1:0]    krnDoneIdx,
  output extStrobe_t           strb
);
  logic [NUM_PAIRS-1:0] busyQ, doneQ, busyNext, doneNext;
  logic                 errQ, errNext;
  logic                 startWr, clearWr, statusRd, startOk;
  logic [PAIR_W-1:0]    startIdx;

  always_comb begin
    strb.wrSel    = (extEn && extWe) ? (NUM_BUFS'(1) << extBufSel) : '0;
    strb.rdStrobe = extEn && !extWe;
    strb.bufSel   = extBufSel;
  end

  assign startWr  = ctlEn && ctlWe && (ctlAddr == CTL_START);
  assign clearWr  = ctlEn && ctlWe && (ctlAddr == CTL_STATUS);
  assign statusRd = ctlEn && !ctlWe;
  assign startIdx = ctlWdata[PAIR_W-1:0];
  assign startOk  = startWr && !busyQ[startIdx];

  always_comb begin
    busyNext = busyQ;
    doneNext = doneQ;
    if (clearWr) doneNext = doneNext & ~ctlWdata[2*NUM_PAIRS-1:NUM_PAIRS];
    if (krnDone) begin
      busyNext[krnDoneIdx] = 1'b0;
      doneNext[krnDoneIdx] = 1'b1;
    end
    if (startOk) busyNext[startIdx] = 1'b1;
    errNext = (errQ && !(clearWr && ctlWdata[CTL_W-1])) ||
              (startWr && busyQ[startIdx]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ       <= '0;
      doneQ       <= '0;
      errQ        <= 1'b0;
      krnStart    <= 1'b0;
      krnStartIdx <= '0;
      ctlRdata    <= '0;
    end else begin
      busyQ    <= busyNext;
      doneQ    <= doneNext;
      errQ     <= errNext;
      krnStart <= startOk;
      if (startOk) krnStartIdx <= startIdx;
      if (statusRd)
        ctlRdata <= (ctlAddr == CTL_STATUS) ? {errQ, doneQ, busyQ} : '0;
    end
  end
endmodule

// File: rtl/cpShellBank.sv
module cpShellBank
  import cpShellPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int WORD_AW = 8
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  extStrobe_t                           strb,
  input  logic [WORD_AW-1:0]                   extWordAddr,
  input  logic [DATA_W-1:0]                    extWdata,
  output logic [DATA_W-1:0]                    extRdata,
  input  logic [NUM_PAIRS-1:0][WORD_AW-1:0]    krnRdAddr,
  output logic [NUM_PAIRS-1:0][DATA_W-1:0]     krnRdData,
  input  logic [NUM_PAIRS-1:0]                 krnWrEn,
  input  logic [NUM_PAIRS-1:0][WORD_AW-1:0]    krnWrAddr,
  input  logic [NUM_PAIRS-1:0][DATA_W-1:0]     krnWrData
);
  localparam int DEPTH = 1 << WORD_AW;

  logic [NUM_BUFS-1:0][DATA_W-1:0] portBRd;
  logic [BUF_SEL_W-1:0]            rdSelQ;

  always_ff @(posedge clk) begin
    if (!rstN) rdSelQ <= '0;
    else if (strb.rdStrobe) rdSelQ <= strb.bufSel;
  end
  assign extRdata = portBRd[rdSelQ];

  for (genvar g = 0; g < NUM_BUFS; g++) begin : gBuf
    logic [DATA_W-1:0] mem [DEPTH];
    logic              portBRdEn;
    assign portBRdEn = strb.rdStrobe && (strb.bufSel == BUF_SEL_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) portBRd[g] <= '0;
      else if (portBRdEn) portBRd[g] <= mem[extWordAddr];
    end

    if (g < NUM_PAIRS) begin : gIn
      always_ff @(posedge clk) begin
        if (strb.wrSel[g]) mem[extWordAddr] <= extWdata;
        krnRdData[g] <= mem[krnRdAddr[g]];
      end
    end else begin : gOut
      always_ff @(posedge clk) begin
        if (krnWrEn[g-NUM_PAIRS])
          mem[krnWrAddr[g-NUM_PAIRS]] <= krnWrData[g-NUM_PAIRS];
        if (strb.wrSel[g]) mem[extWordAddr] <= extWdata;
      end
    end
  end
endmodule

// File: rtl/cpBufShell.sv
module cpBufShell
  import cpShellPkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BUF_WORDS = 256,
  localparam int WORD_AW  = $clog2(BUF_WORDS),
  localparam int EXT_AW   = WORD_AW + BUF_SEL_W
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              extEn,
  input  logic                              extWe,
  input  logic [EXT_AW-1:0]                 extAddr,
  input  logic [DATA_W-1:0]                 extWdata,
  output logic [DATA_W-1:0]                 extRdata,
  input  logic                              ctlEn,
  input  logic                              ctlWe,
  input  logic [1:0]                        ctlAddr,
  input  logic [CTL_W-1:0]                  ctlWdata,
  output logic [CTL_W-1:0]                  ctlRdata,
  output logic                              krnStart,
  output logic [PAIR_W-1:0]                 krnStartIdx,
  input  logic                              krnDone,
  input  logic [PAIR_W-1:0]                 krnDoneIdx,
  input  logic [NUM_PAIRS-1:0][WORD_AW-1:0] krnRdAddr,
  output logic [NUM_PAIRS-1:0][DATA_W-1:0]  krnRdData,
  input  logic [NUM_PAIRS-1:0]              krnWrEn,
  input  logic [NUM_PAIRS-1:0][WORD_AW-1:0] krnWrAddr,
  input  logic [NUM_PAIRS-1:0][DATA_W-1:0]  krnWrData
);
  extStrobe_t strb;

  cpShellCtrl uCtrl (
    .clk(clk), .rstN(rstN),
    .extEn(extEn), .extWe(extWe), .extBufSel(extAddr[EXT_AW-1 -: BUF_SEL_W]),
    .ctlEn(ctlEn), .ctlWe(ctlWe), .ctlAddr(ctlAddr),
    .ctlWdata(ctlWdata), .ctlRdata(ctlRdata),
    .krnStart(krnStart), .krnStartIdx(krnStartIdx),
    .krnDone(krnDone), .krnDoneIdx(krnDoneIdx),
    .strb(strb)
  );

  cpShellBank #(.DATA_W(DATA_W), .WORD_AW(WORD_AW)) uBank (
    .clk(clk), .rstN(rstN), .strb(strb),
    .extWordAddr(extAddr[WORD_AW-1:0]), .extWdata(extWdata), .extRdata(extRdata),
    .krnRdAddr(krnRdAddr), .krnRdData(krnRdData),
    .krnWrEn(krnWrEn), .krnWrAddr(krnWrAddr), .krnWrData(krnWrData)
  );
endmodule

// File: rtl/cpShellChecker.sv
module cpShellChecker
  import cpShellPkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              extEn,
  input logic              extWe,
  input logic [DATA_W-1:0] extRdata,
  input logic              ctlEn,
  input logic              ctlWe,
  input logic [1:0]        ctlAddr,
  input logic [CTL_W-1:0]  ctlWdata,
  input logic [CTL_W-1:0]  ctlRdata,
  input logic              krnStart,
  input logic [PAIR_W-1:0] krnStartIdx
);
  assert_start_from_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    krnStart |-> $past(ctlEn && ctlWe && ctlAddr == CTL_START));

  assert_start_index_R6: assert property (@(posedge clk) disable iff (!rstN)
    krnStart |-> krnStartIdx == $past(ctlWdata[PAIR_W-1:0]));

  assert_ctl_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctlEn && !ctlWe) |-> $stable(ctlRdata));

  assert_ext_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(extEn && !extWe) |-> $stable(extRdata));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(!rstN) |-> !krnStart && ctlRdata == '0);
endmodule

bind cpBufShell cpShellChecker #(.DATA_W(DATA_W)) uChk (.*);

// File: tb/sim_cpBufShell.sv
module sim_cpBufShell;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int EAW = AW + 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extEn = 0, extWe = 0;
  logic [EAW-1:0] extAddr = '0;
  logic [DW-1:0] extWdata = '0, extRdata;
  logic ctlEn = 0, ctlWe = 0;
  logic [1:0] ctlAddr = '0;
  logic [8:0] ctlWdata = '0, ctlRdata;
  logic krnStart;
  logic [1:0] krnStartIdx;
  logic krnDone = 0;
  logic [1:0] krnDoneIdx = '0;
  logic [3:0][AW-1:0] krnRdAddr = '0;
  logic [3:0][DW-1:0] krnRdData;
  logic [3:0] krnWrEn = '0;
  logic [3:0][AW-1:0] krnWrAddr = '0;
  logic [3:0][DW-1:0] krnWrData = '0;

  int nRun = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpBufShell #(.DATA_W(DW), .BUF_WORDS(256)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [EAW-1:0] ea(input int buf_, input int word);
    return EAW'(buf_ * 256 + word);
  endfunction

  task automatic extWr(input logic [EAW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); extEn = 1; extWe = 1; extAddr = a; extWdata = d;
    @(negedge clk); extEn = 0; extWe = 0;
  endtask

  task automatic extRd(input logic [EAW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); extEn = 1; extWe = 0; extAddr = a;
    @(negedge clk); extEn = 0; d = extRdata;
  endtask

  task automatic ctlWr(input logic [1:0] a, input logic [8:0] d);
    @(negedge clk); ctlEn = 1; ctlWe = 1; ctlAddr = a; ctlWdata = d;
    @(negedge clk); ctlEn = 0; ctlWe = 0;
  endtask

  task automatic ctlRd(input logic [1:0] a, output logic [8:0] d);
    @(negedge clk); ctlEn = 1; ctlWe = 0; ctlAddr = a;
    @(negedge clk); ctlEn = 0; d = ctlRdata;
  endtask

  task automatic doneEv(input logic [1:0] k);
    @(negedge clk); krnDone = 1; krnDoneIdx = k;
    @(negedge clk); krnDone = 0;
  endtask

  task automatic testReset();
    logic [8:0] s;
    chk("R1 krnStart", 32'(krnStart), 0);
    chk("R1 extRdata", extRdata, 0);
    ctlRd(2'd1, s);
    chk("R1 status", 32'(s), 0);
  endtask

  task automatic testFlatMap();
    logic [DW-1:0] d;
    for (int b = 0; b < 8; b++) extWr(ea(b, 255 - b), 32'hA000_0000 + b);
    extWr(ea(2, 0), 32'h1234_5678);
    for (int b = 0; b < 8; b++) begin
      extRd(ea(b, 255 - b), d);
      chk("R2 buffer word", d, 32'hA000_0000 + b);
    end
    extRd(ea(2, 0), d);
    chk("R2 word zero", d, 32'h1234_5678);
  endtask

  task automatic testKernelRead();
    for (int i = 0; i < 4; i++) extWr(ea(i, 10 + i), 32'hB000_0000 + i);
    @(negedge clk);
    for (int i = 0; i < 4; i++) krnRdAddr[i] = AW'(10 + i);
    @(negedge clk);
    for (int i = 0; i < 4; i++) chk("R3 kernel read", krnRdData[i], 32'hB000_0000 + i);
  endtask

  task automatic testKernelWrite();
    logic [DW-1:0] d;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      krnWrEn[i] = 1; krnWrAddr[i] = AW'(20 + i); krnWrData[i] = 32'hC000_0000 + i;
    end
    @(negedge clk); krnWrEn = '0;
    for (int i = 0; i < 4; i++) begin
      extRd(ea(4 + i, 20 + i), d);
      chk("R4 kernel write", d, 32'hC000_0000 + i);
    end
  endtask

  task automatic testStart();
    logic [8:0] s;
    ctlWr(2'd0, 9'd2);
    chk("R6 start pulse", 32'(krnStart), 1);
    chk("R6 start index", 32'(krnStartIdx), 2);
    @(negedge clk);
    chk("R6 single pulse", 32'(krnStart), 0);
    ctlRd(2'd1, s);
    chk("R6 busy bit", 32'(s), 32'h004);
    ctlRd(2'd0, s);
    chk("R10 start reads zero", 32'(s), 0);
  endtask

  task automatic testBusyStart();
    logic [8:0] s;
    ctlWr(2'd0, 9'd2);
    chk("R7 no pulse", 32'(krnStart), 0);
    @(negedge clk);
    chk("R7 no late pulse", 32'(krnStart), 0);
    ctlRd(2'd1, s);
    chk("R7 error set", 32'(s), 32'h104);
    ctlWr(2'd1, 9'h100);
    ctlRd(2'd1, s);
    chk("R9 error cleared", 32'(s), 32'h004);
  endtask

  task automatic testDone();
    logic [8:0] s;
    doneEv(2'd2);
    ctlRd(2'd1, s);
    chk("R8 done set busy clear", 32'(s), 32'h040);
    ctlRd(2'd1, s);
    chk("R8 done sticky", 32'(s), 32'h040);
    chk("R10 rdata held", 32'(ctlRdata), 32'h040);
    ctlWr(2'd1, 9'h040);
    ctlRd(2'd1, s);
    chk("R9 done cleared", 32'(s), 0);
  endtask

  task automatic testSetWins();
    logic [8:0] s;
    ctlWr(2'd0, 9'd1);
    @(negedge clk);
    krnDone = 1; krnDoneIdx = 2'd1;
    ctlEn = 1; ctlWe = 1; ctlAddr = 2'd1; ctlWdata = 9'h020;
    @(negedge clk);
    krnDone = 0; ctlEn = 0; ctlWe = 0;
    ctlRd(2'd1, s);
    chk("R9 set wins", 32'(s), 32'h020);
    ctlWr(2'd1, 9'h1F0);
  endtask

  task automatic testPingPong();
    logic [DW-1:0] d;
    logic [8:0] s;
    extWr(ea(0, 50), 32'hD000_0000);
    extWr(ea(7, 60), 32'hD700_0000);
    ctlWr(2'd0, 9'd0);
    chk("R5 start pair0", 32'(krnStart), 1);
    @(negedge clk);
    extEn = 1; extWe = 1; extAddr = ea(1, 50); extWdata = 32'hD100_0000;
    krnRdAddr[0] = AW'(50);
    krnWrEn[0] = 1; krnWrAddr[0] = AW'(70); krnWrData[0] = 32'hD400_0000;
    @(negedge clk);
    extEn = 0; extWe = 0; krnWrEn = '0;
    chk("R5 kernel read during load", krnRdData[0], 32'hD000_0000);
    extRd(ea(1, 50), d);
    chk("R5 load other buffer", d, 32'hD100_0000);
    extRd(ea(4, 70), d);
    chk("R5 kernel output", d, 32'hD400_0000);
    extRd(ea(7, 60), d);
    chk("R5 untouched buffer", d, 32'hD700_0000);
    doneEv(2'd0);
    ctlRd(2'd1, s);
    chk("R8 pair0 done", 32'(s), 32'h010);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testFlatMap();
    testKernelRead();
    testKernelWrite();
    testStart();
    testBusyStart();
    testDone();
    testSetWins();
    testPingPong();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule